// File: doc/BRIEF.md
# Nested Multi-Level Interrupt Controller

This block collects interrupt requests from seven sources (two external inputs, three timer overflows, a serial port and a counter array) and decides which of them the processor should service next. Each source has an enable bit, and a global enable gates all of them together. Each source also has a two-bit priority level, built from a bit in a high-priority register and a bit in a low-priority register, which gives four levels. The controller latches incoming request pulses as pending flags. It picks the pending, enabled source with the highest level, and offers that source's index to the processor.

The controller tracks which levels are in service with a four-bit mask. A new request is offered only when its level is strictly above the highest level in service. A lower-level handler can therefore be interrupted by a higher one but not by one of its own level, and a handler at level 3 is never interrupted. When the processor accepts the offer, the controller clears that source's pending flag and records its level as in service. A return strobe ends the most deeply nested handler by clearing the highest in-service bit.

A small control state machine drives the processor handshake. It has three states. ST_QUIET means no request is offered. ST_OFFER means `irq_req` is high and `irq_idx` is valid. ST_TAKEN is a one-cycle blanking state after an accept. The transitions are as follows:
- quiet-to-offer, when an eligible winner exists.
- offer-to-taken, on `irq_ack`.
- offer-to-quiet, when the winner disappears without an accept.
- taken-to-quiet, unconditionally.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset, the enable, low-priority, high-priority and pending registers all read 0x00, and `irq_req` is low.
- R2: The register addresses are as follows: 0 is enable, 1 is low-priority bits, 2 is high-priority bits, 3 is pending. In all four registers, bit i belongs to source index i. The source indices are: external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial port = 4, timer 2 = 5, counter array = 6. Enable bit 7 is the global enable. Registers 0 to 2 read back what was written.
- R3: While global enable (bit 7 of register 0) is 0, `irq_req` stays low, and a request pulse still sets its pending flag.
- R4: A source whose enable bit is 0 is never offered. Its pending flag stays set, and the source is offered once its enable bit is set.
- R5: A source's level is {high bit, low bit}. Among eligible sources, the one with the highest level is offered.
- R6: Among eligible sources of equal level, the one with the lowest source index is offered.
- R7: A one-cycle request pulse sampled at clock edge N with the controller idle causes `irq_req` to be high after edge N+1, with `irq_idx` set to the source index.
- R8: An accept (`irq_ack` while `irq_req` is high) clears the source's pending flag, marks its level in service, and makes `irq_req` low in the following cycle.
- R9: A pending request is offered during a handler only if its level is strictly greater than every level in service. Requests of equal or lower level wait.
- R10: While level 3 is in service, `irq_req` stays low.
- R11: `reti` clears only the highest set in-service bit, so the next lower handler level is restored.
- R12: A request pulse on a source in the same cycle as the accept of that source leaves its pending flag set.
- R13: Writing to register 3 clears each pending flag whose data bit is 1, and leaves the other flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| src_req | input | 7 | One-cycle request pulses, bit i = source i |
| irq_req | output | 1 | Interrupt offered to the processor |
| irq_idx | output | 3 | Index of the offered source |
| irq_ack | input | 1 | Processor accepts the offer |
| reti | input | 1 | Return-from-interrupt strobe |

## Verification
Two functions can fall in the same clock cycle: the accept, which clears a pending flag, and a fresh request pulse from the same source, which sets it. The bench provokes this by asserting `irq_ack` and `src_req` for the offered source on the same edge. It then reads register 3, expecting the flag to still be set. It also confirms that no new offer appears while the same level is in service, and that the source is offered again after `reti`. Nesting is judged in a similar way: the bench interleaves accepts and returns, and checks which index, if any, is offered after each step.

// File: rtl/nic_pkg.sv
package nic_pkg;
    localparam int NSRC   = 7;
    localparam int NLVL   = 4;
    localparam int LVL_W  = $clog2(NLVL);
    localparam int IDX_W  = $clog2(NSRC);
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_EN   = 2'd0;
    localparam logic [ADDR_W-1:0] A_PLO  = 2'd1;
    localparam logic [ADDR_W-1:0] A_PHI  = 2'd2;
    localparam logic [ADDR_W-1:0] A_PEND = 2'd3;

    typedef enum logic [1:0] {
        ST_QUIET = 2'd0,
        ST_OFFER = 2'd1,
        ST_TAKEN = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/nic_regs.sv
module nic_regs
    import nic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSRC-1:0]   pend,
    output logic [NSRC:0]     en_q,
    output logic [NSRC-1:0]   plo_q,
    output logic [NSRC-1:0]   phi_q,
    output logic [NSRC-1:0]   clr_mask,
    output logic [DATA_W-1:0] rdata
);
    localparam int PAD = DATA_W - NSRC;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            plo_q <= '0;
            phi_q <= '0;
        end else if (wr) begin
            if (addr == A_EN)  en_q  <= wdata[NSRC:0];
            if (addr == A_PLO) plo_q <= wdata[NSRC-1:0];
            if (addr == A_PHI) phi_q <= wdata[NSRC-1:0];
        end
    end

    // Write-one-to-clear strobe towards the pending flags.
    assign clr_mask = (wr && addr == A_PEND) ? wdata[NSRC-1:0] : '0;

    always_comb begin
        unique case (addr)
            A_EN:    rdata = en_q;
            A_PLO:   rdata = {{PAD{1'b0}}, plo_q};
            A_PHI:   rdata = {{PAD{1'b0}}, phi_q};
            default: rdata = {{PAD{1'b0}}, pend};
        endcase
    end
endmodule

// File: rtl/nic_pending.sv
module nic_pending
    import nic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  set_pulse,
    input  logic [NSRC-1:0]  sw_clr,
    input  logic             take,
    input  logic [IDX_W-1:0] take_idx,
    output logic [NSRC-1:0]  pend
);
    for (genvar g = 0; g < NSRC; g++) begin : g_flag
        logic ack_hit;
        assign ack_hit = take && (take_idx == IDX_W'(g));
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[g] <= 1'b0;
            else if (set_pulse[g])
                pend[g] <= 1'b1;          // a fresh request outranks any clear
            else if (ack_hit || sw_clr[g])
                pend[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
    import nic_pkg::*;
(
    input  logic [NSRC-1:0]  pend,
    input  logic [NSRC:0]    en_q,
    input  logic [NSRC-1:0]  plo_q,
    input  logic [NSRC-1:0]  phi_q,
    input  logic             svc_active,
    input  logic [LVL_W-1:0] svc_top,
    output logic             win_ok,
    output logic [IDX_W-1:0] win_idx,
    output logic [LVL_W-1:0] win_lvl
);
    logic [NSRC-1:0]  elig;
    logic [LVL_W-1:0] lvl [NSRC];
    logic             found;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign lvl[g]  = {phi_q[g], plo_q[g]};
        assign elig[g] = pend[g] & en_q[g] & en_q[NSRC];
    end

    // Scan in polling order; only a strictly higher level replaces the
    // current choice, so the earliest source wins a tie.
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (!found || lvl[i] > win_lvl)) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
                win_lvl = lvl[i];
            end
        end
    end

    assign win_ok = found && (!svc_active || win_lvl > svc_top);
endmodule

// File: rtl/nic_inservice.sv
module nic_inservice
    import nic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [LVL_W-1:0] set_lvl,
    input  logic             drop,
    output logic [NLVL-1:0]  mask,
    output logic             active,
    output logic [LVL_W-1:0] top
);
    logic [NLVL-1:0] mask_d;

    always_comb begin
        top = '0;
        for (int i = 0; i < NLVL; i++)
            if (mask[i]) top = LVL_W'(i);
    end
    assign active = |mask;

    always_comb begin
        mask_d = mask;
        if (drop && active) mask_d[top] = 1'b0;
        if (set_en)         mask_d[set_lvl] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask <= '0;
        else        mask <= mask_d;
    end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NSRC-1:0]   src_req,
    output logic              irq_req,
    output logic [IDX_W-1:0]  irq_idx,
    input  logic              irq_ack,
    input  logic              reti
);
    logic [NSRC:0]     en_q;
    logic [NSRC-1:0]   plo_q, phi_q, clr_mask, pend;
    logic [NLVL-1:0]   svc_mask;
    logic              svc_active, win_ok, take;
    logic [LVL_W-1:0]  svc_top, win_lvl, lvl_q;
    logic [IDX_W-1:0]  win_idx, idx_q;
    ctl_state_e        state_q, state_d;

    nic_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .pend(pend), .en_q(en_q), .plo_q(plo_q),
        .phi_q(phi_q), .clr_mask(clr_mask), .rdata(reg_rdata)
    );

    nic_pending u_pend (
        .clk(clk), .rst_n(rst_n), .set_pulse(src_req), .sw_clr(clr_mask),
        .take(take), .take_idx(idx_q), .pend(pend)
    );

    nic_arbiter u_arb (
        .pend(pend), .en_q(en_q), .plo_q(plo_q), .phi_q(phi_q),
        .svc_active(svc_active), .svc_top(svc_top),
        .win_ok(win_ok), .win_idx(win_idx), .win_lvl(win_lvl)
    );

    nic_inservice u_svc (
        .clk(clk), .rst_n(rst_n), .set_en(take), .set_lvl(lvl_q),
        .drop(reti), .mask(svc_mask), .active(svc_active), .top(svc_top)
    );

    assign take = irq_ack && (state_q == ST_OFFER);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: if (win_ok) state_d = ST_OFFER;
            ST_OFFER: begin
                if (take)         state_d = ST_TAKEN;
                else if (!win_ok) state_d = ST_QUIET;
            end
            ST_TAKEN: state_d = ST_QUIET;
            default:  state_d = ST_QUIET;
        endcase
    end

    // Offered source and its level, held for the accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            lvl_q <= '0;
        end else if (state_d == ST_OFFER) begin
            idx_q <= win_idx;
            lvl_q <= win_lvl;
        end
    end

    assign irq_req = (state_q == ST_OFFER);
    assign irq_idx = idx_q;
endmodule

// File: rtl/nic_checker.sv
module nic_checker
    import nic_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             irq_req,
    input logic [IDX_W-1:0] irq_idx,
    input logic             reti,
    input logic             take,
    input logic [NSRC:0]    en_q,
    input logic [NLVL-1:0]  svc_mask
);
    // R3: an offer needs global enable in the cycle before
    a_r3_req_needs_global: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(en_q[NSRC]));

    // R7: offered index names a real source
    a_r7_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_idx < IDX_W'(NSRC)));

    // R8: accept drops the request next cycle
    a_r8_quiet_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !irq_req);

    // R8: accept adds exactly one in-service level
    a_r8_take_marks_level: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !reti) |=> ($countones(svc_mask) == $countones($past(svc_mask)) + 1));

    // R11: return removes exactly one in-service level
    a_r11_reti_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !take && svc_mask != '0)
            |=> ($countones(svc_mask) + 1 == $countones($past(svc_mask))));

    // R10: nothing is offered while the top level runs
    a_r10_top_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        svc_mask[NLVL-1] |-> !irq_req);
endmodule

bind nest_irq_ctrl nic_checker u_chk (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_idx(irq_idx),
    .reti(reti), .take(take), .en_q(en_q), .svc_mask(svc_mask)
);

// File: tb/nest_irq_ctrl_test.sv
`timescale 1ns/1ps
module nest_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [6:0] src_req = '0;
    logic       irq_req;
    logic [2:0] irq_idx;
    logic       irq_ack = 1'b0;
    logic       reti = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nest_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_req(src_req),
        .irq_req(irq_req), .irq_idx(irq_idx), .irq_ack(irq_ack), .reti(reti)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        src_req = '0; irq_ack = 1'b0; reti = 1'b0; reg_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic pulse(input logic [6:0] m);
        src_req = m;
        @(negedge clk);
        src_req = '0;
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic ret();
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
    endtask

    // Wait up to 8 cycles for an offer; idx is -1 if none appears.
    task automatic wait_offer(output int idx);
        idx = -1;
        for (int i = 0; i < 8; i++) begin
            if (irq_req) begin
                idx = int'(irq_idx);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        int v;
        do_reset();
        chk("R1 irq_req", int'(irq_req), 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reg", v, 0);
        end
    endtask

    task automatic t_regs();
        int v;
        do_reset();
        wr(2'd0, 8'hA5); wr(2'd1, 8'h5A); wr(2'd2, 8'h33);
        rd(2'd0, v); chk("R2 enable", v, 8'hA5);
        rd(2'd1, v); chk("R2 prio lo", v, 8'h5A);
        rd(2'd2, v); chk("R2 prio hi", v, 8'h33);
    endtask

    task automatic t_timing();
        do_reset();
        wr(2'd0, 8'h88);
        pulse(7'h08);
        chk("R7 not yet", int'(irq_req), 0);
        @(negedge clk);
        chk("R7 req", int'(irq_req), 1);
        chk("R7 idx", int'(irq_idx), 3);
    endtask

    task automatic t_global();
        int v, idx;
        do_reset();
        wr(2'd0, 8'h01);
        pulse(7'h01);
        wait_offer(idx); chk("R3 no offer", idx, -1);
        rd(2'd3, v); chk("R3 pending kept", v, 1);
        wr(2'd0, 8'h81);
        wait_offer(idx); chk("R3 offer after global", idx, 0);
        ack();
        chk("R8 quiet after ack", int'(irq_req), 0);
        rd(2'd3, v); chk("R8 pending cleared", v, 0);
        ret();
    endtask

    task automatic t_source_en();
        int v, idx;
        do_reset();
        wr(2'd0, 8'h80);
        pulse(7'h04);
        wait_offer(idx); chk("R4 disabled no offer", idx, -1);
        rd(2'd3, v); chk("R4 pending kept", v, 4);
        wr(2'd0, 8'h84);
        wait_offer(idx); chk("R4 offer when enabled", idx, 2);
    endtask

    task automatic t_level();
        int idx;
        do_reset();
        wr(2'd0, 8'h91);
        wr(2'd2, 8'h10);              // serial port at level 2
        pulse(7'h11);
        wait_offer(idx); chk("R5 higher level wins", idx, 4);
        ack();
        wait_offer(idx); chk("R9 lower waits", idx, -1);
        ret();
        wait_offer(idx); chk("R9 lower after return", idx, 0);
    endtask

    task automatic t_tie();
        int idx;
        do_reset();
        wr(2'd0, 8'h8C);
        wr(2'd1, 8'h0C);              // ext 1 and timer 1 at level 1
        pulse(7'h0C);
        wait_offer(idx); chk("R6 tie lowest index", idx, 2);
        ack();
        wait_offer(idx); chk("R9 equal level waits", idx, -1);
        ret();
        wait_offer(idx); chk("R6 second of tie", idx, 3);
    endtask

    task automatic t_nest();
        int idx;
        do_reset();
        wr(2'd0, 8'h83);
        wr(2'd1, 8'h02);              // timer 0 at level 1, ext 0 at level 0
        pulse(7'h01);
        wait_offer(idx); chk("R9 base offer", idx, 0);
        ack();
        pulse(7'h02);
        wait_offer(idx); chk("R9 higher preempts", idx, 1);
        ack();
        ret();                        // must drop level 1 only
        pulse(7'h02);
        wait_offer(idx); chk("R11 level 1 freed", idx, 1);
        ack();
        ret();
        ret();
        pulse(7'h01);
        wait_offer(idx); chk("R11 all levels freed", idx, 0);
    endtask

    task automatic t_top();
        int idx;
        do_reset();
        wr(2'd0, 8'hD0);
        wr(2'd1, 8'h50); wr(2'd2, 8'h50);   // counter array and serial at level 3
        pulse(7'h40);
        wait_offer(idx); chk("R10 top offer", idx, 6);
        ack();
        pulse(7'h10);
        wait_offer(idx); chk("R10 no preempt", idx, -1);
        ret();
        wait_offer(idx); chk("R10 after return", idx, 4);
    endtask

    task automatic t_collide();
        int v, idx;
        do_reset();
        wr(2'd0, 8'h81);
        pulse(7'h01);
        wait_offer(idx); chk("R12 offer", idx, 0);
        irq_ack = 1'b1; src_req = 7'h01;
        @(negedge clk);
        irq_ack = 1'b0; src_req = '0;
        rd(2'd3, v); chk("R12 pending survives", v, 1);
        wait_offer(idx); chk("R12 same level waits", idx, -1);
        ret();
        wait_offer(idx); chk("R12 reoffer", idx, 0);
    endtask

    task automatic t_swclr();
        int v;
        do_reset();
        pulse(7'h23);
        rd(2'd3, v); chk("R13 latched", v, 8'h23);
        wr(2'd3, 8'h21);
        rd(2'd3, v); chk("R13 cleared", v, 8'h02);
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_regs();
        t_timing();
        t_global();
        t_source_en();
        t_level();
        t_tie();
        t_nest();
        t_top();
        t_collide();
        t_swclr();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule